// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines for one interrupt controller. Each line is captured into a pending register. A line is captured either on a rising edge or by following the input level, chosen line by line. Pending lines that are not masked compete for service. Priority is counted from a rotating base: priority index p selects line (p + base) mod 8, and the lowest index wins. The block raises its interrupt output only when that winner ranks strictly ahead of everything already in service.

The host acknowledges with a one-cycle strobe. The block then moves the winner into the in-service register and returns its 3-bit line number. Auto end-of-interrupt can be enabled; with it, the in-service bit is released at once and the base can optionally rotate. A small command port carries the other operations: general and line-specific end-of-interrupt, with or without rotation, explicit base setting, and turning auto-rotation on or off. When the block is the primary of a cascaded pair, a special nested mode leaves the cascade line out of the in-service comparison.

Top module: `prio_irq_resolver`

## Requirements
- R1: After synchronous reset the pending, in-service, mask and trigger-mode registers are zero, the base is 0, `int_req` is 0 and `ack_level` is 0.
- R2: Priority index p maps to line (p + base) mod 8, and the lowest index among unmasked pending lines wins. With base 0, line 0 ranks highest.
- R3: `int_req` is raised only when the winning pending index is strictly lower than the best in-service index. An empty in-service register counts as index 8.
- R4: A level-mode line's pending bit follows its input one cycle later. An edge-mode line's pending bit sets only when the input goes from 0 to 1, and a held-high input does not set it again.
- R5: `ack` while a request is valid sets the winner's in-service bit, clears its pending bit only if the line is in edge mode, and returns the line on `ack_level` together with `ack_done` one cycle later.
- R6: With `auto_eoi` high, an acknowledge leaves the in-service register unchanged. If auto-rotation is on, the base becomes (line + 1) mod 8.
- R7: `cmd_op` encodings: 0 no-op, 1 clear the highest-ranked in-service bit, 2 clear in-service bit `cmd_level`, 3 like 1 and set base to (cleared line + 1), 4 like 2 and set base to (`cmd_level` + 1), 5 set base to (`cmd_level` + 1), 6 auto-rotation on, 7 auto-rotation off.
- R8: Any end-of-interrupt on a line also clears that line's pending bit and its remembered input level.
- R9: Lines set in parameter `FIXED_EDGE_MASK` (default lines 0 to 2) stay in edge mode whatever is written through `trig_data`.
- R10: When `IS_PRIMARY` is set and `sfn_mode` is high, the in-service bit of line `CASCADE_LINE` (default 2) is left out of the R3 comparison.
- R11: A pending line whose `mask_data` bit is 1 takes no part in arbitration until the bit is cleared.
- R12: `ack` while no request is valid returns level 7 and changes neither the pending nor the in-service register.
- R13: `int_req` and `int_level` are registered. They reflect a change of the pending, mask, in-service or base state one cycle after that state changes, so a request captured at edge k shows at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request input lines |
| trig_wr | input | 1 | Write strobe for the trigger-mode register |
| trig_data | input | 8 | Trigger mode per line, 1 = level |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_data | input | 8 | Mask per line, 1 = masked |
| sfn_mode | input | 1 | Special nested mode enable |
| auto_eoi | input | 1 | Auto end-of-interrupt enable |
| cmd_wr | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (R7) |
| cmd_level | input | 3 | Line argument of a command |
| ack | input | 1 | Acknowledge strobe |
| int_req | output | 1 | Registered interrupt request |
| int_level | output | 3 | Registered winning line |
| ack_done | output | 1 | Pulses one cycle after every acknowledge |
| ack_level | output | 3 | Line returned by the last acknowledge |
| irr_out | output | 8 | Pending register |
| isr_out | output | 8 | In-service register |

## Verification
Pending and in-service bits change at the edge that samples the input, acknowledge or command, so they are read at the falling edge just after it. `int_req` and `int_level` trail that state by one more edge, and the bench waits one extra cycle before checking them; one case samples both edges to confirm the lag. Each acknowledge pushes its expected line into a queue. A monitor pops an entry whenever `ack_done` is high, which is the cycle after the strobe.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP          = 3'd0,
    CMD_EOI_TOP      = 3'd1,
    CMD_EOI_LINE     = 3'd2,
    CMD_EOI_TOP_ROT  = 3'd3,
    CMD_EOI_LINE_ROT = 3'd4,
    CMD_SET_BASE     = 3'd5,
    CMD_AROT_ON      = 3'd6,
    CMD_AROT_OFF     = 3'd7
  } resolver_cmd_e;

endpackage

// File: rtl/prio_find.sv
// Rotated priority encoder: lowest index p whose line (p + base) mod N is set.
module prio_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  input  logic [LW-1:0] base,
  output logic          found,
  output logic [LW:0]   prio
);

  always_comb begin
    found = 1'b0;
    prio  = (LW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (bits[LW'(LW'(p) + base)]) begin
        found = 1'b1;
        prio  = (LW+1)'(p);
      end
    end
  end

endmodule

// File: rtl/irq_line_capture.sv
// One request line: edge or level capture, cleared by acknowledge or end-of-interrupt.
module irq_line_capture (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic level_mode,
  input  logic ack_clear,
  input  logic drop,
  output logic pending
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      last_q <= drop ? 1'b0 : req_in;
      if (drop)
        pending <= 1'b0;
      else if (level_mode)
        pending <= req_in;
      else if (req_in && !last_q)
        pending <= 1'b1;
      else if (ack_clear)
        pending <= 1'b0;
    end
  end

  AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(req_in)); // R4

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (level_mode && !drop) |=> (pending == $past(req_in))); // R4

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    drop |=> !pending); // R8

endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter int          N               = 8,
  parameter int          IS_PRIMARY      = 1,
  parameter int          CASCADE_LINE    = 2,
  parameter int unsigned FIXED_EDGE_MASK = 32'h0000_0007,
  localparam int         LW              = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          trig_wr,
  input  logic [N-1:0]  trig_data,
  input  logic          mask_wr,
  input  logic [N-1:0]  mask_data,
  input  logic          sfn_mode,
  input  logic          auto_eoi,
  input  logic          cmd_wr,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_level,
  input  logic          ack,
  output logic          int_req,
  output logic [LW-1:0] int_level,
  output logic          ack_done,
  output logic [LW-1:0] ack_level,
  output logic [N-1:0]  irr_out,
  output logic [N-1:0]  isr_out
);

  localparam logic [N-1:0] FIXED_EDGE = FIXED_EDGE_MASK[N-1:0];
  localparam logic [N-1:0] ONE        = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  trig_q, imr_q, isr_q, irr;
  logic [LW-1:0] base_q, base_n;
  logic          arot_q, arot_n;

  logic [N-1:0]  pend_vec, serv_vec, drop_vec, isr_set, ack_clr;
  logic          pend_any, serv_any, top_any, cand_valid, ack_take;
  logic [LW:0]   pend_p, serv_p, top_p;
  logic [LW-1:0] pend_line, top_line;
  resolver_cmd_e op;

  assign op = resolver_cmd_e'(cmd_op);

  // Request capture, one instance per line
  for (genvar i = 0; i < N; i++) begin : g_line
    irq_line_capture u_cap (
      .clk        (clk),
      .rst        (rst),
      .req_in     (irq_in[i]),
      .level_mode (trig_q[i]),
      .ack_clear  (ack_clr[i]),
      .drop       (drop_vec[i]),
      .pending    (irr[i])
    );
  end

  // Arbitration
  assign pend_vec = irr & ~imr_q;

  always_comb begin
    serv_vec = isr_q;
    if (IS_PRIMARY != 0 && sfn_mode) serv_vec[CASCADE_LINE] = 1'b0;
  end

  prio_find #(.N(N), .LW(LW)) u_pend (.bits(pend_vec), .base(base_q), .found(pend_any), .prio(pend_p));
  prio_find #(.N(N), .LW(LW)) u_serv (.bits(serv_vec), .base(base_q), .found(serv_any), .prio(serv_p));
  prio_find #(.N(N), .LW(LW)) u_top  (.bits(isr_q),    .base(base_q), .found(top_any),  .prio(top_p));

  assign pend_line  = LW'(pend_p[LW-1:0] + base_q);
  assign top_line   = LW'(top_p[LW-1:0] + base_q);
  assign cand_valid = pend_any && (!serv_any || (pend_p < serv_p));
  assign ack_take   = ack && cand_valid;

  // Commands, acknowledge and auto end-of-interrupt
  always_comb begin
    drop_vec = '0;
    base_n   = base_q;
    arot_n   = arot_q;
    if (cmd_wr) begin
      case (op)
        CMD_EOI_TOP:      if (top_any) drop_vec = ONE << top_line;
        CMD_EOI_TOP_ROT:  if (top_any) begin
                            drop_vec = ONE << top_line;
                            base_n   = LW'(top_line + 1'b1);
                          end
        CMD_EOI_LINE:     drop_vec = ONE << cmd_level;
        CMD_EOI_LINE_ROT: begin
                            drop_vec = ONE << cmd_level;
                            base_n   = LW'(cmd_level + 1'b1);
                          end
        CMD_SET_BASE:     base_n = LW'(cmd_level + 1'b1);
        CMD_AROT_ON:      arot_n = 1'b1;
        CMD_AROT_OFF:     arot_n = 1'b0;
        default:          ;
      endcase
    end
    isr_set = ack_take ? (ONE << pend_line) : '0;
    ack_clr = isr_set & ~trig_q;
    if (ack_take && auto_eoi) begin
      drop_vec = drop_vec | isr_set;
      isr_set  = '0;
      if (arot_q) base_n = LW'(pend_line + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= '0;
      imr_q     <= '0;
      isr_q     <= '0;
      base_q    <= '0;
      arot_q    <= 1'b0;
      int_req   <= 1'b0;
      int_level <= '0;
      ack_done  <= 1'b0;
      ack_level <= '0;
    end else begin
      if (trig_wr) trig_q <= trig_data & ~FIXED_EDGE;
      if (mask_wr) imr_q  <= mask_data;
      isr_q     <= (isr_q | isr_set) & ~drop_vec;
      base_q    <= base_n;
      arot_q    <= arot_n;
      int_req   <= cand_valid;
      int_level <= pend_line;
      ack_done  <= ack;
      if (ack) ack_level <= ack_take ? pend_line : LW'(N - 1);
    end
  end

  assign irr_out = irr;
  assign isr_out = isr_q;

  AST_ACK_EMPTY_NOCHANGE: assert property (@(posedge clk) disable iff (rst)
    (ack && !cand_valid && !cmd_wr) |=> (ack_level == LW'(N - 1) && isr_q == $past(isr_q))); // R12

  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (ack && !cmd_wr) |=> ($countones(isr_q & ~$past(isr_q)) <= 1)); // R5

  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi && !cmd_wr) |=> ((isr_q & ~$past(isr_q)) == '0)); // R6

  AST_REQ_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (int_req && !(IS_PRIMARY != 0 && int_level == LW'(CASCADE_LINE)))
      |-> ((($past(isr_q)) & (ONE << int_level)) == '0)); // R3

endmodule

// File: tb/prio_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module prio_irq_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0, trig_data = '0, mask_data = '0;
  logic       trig_wr = 1'b0, mask_wr = 1'b0, sfn_mode = 1'b0, auto_eoi = 1'b0;
  logic       cmd_wr = 1'b0, ack = 1'b0;
  logic [2:0] cmd_op = '0, cmd_level = '0;
  logic       int_req, ack_done;
  logic [2:0] int_level, ack_level;
  logic [7:0] irr_out, isr_out;

  int n_run = 0, n_fail = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  prio_irq_resolver dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig_wr(trig_wr), .trig_data(trig_data),
    .mask_wr(mask_wr), .mask_data(mask_data), .sfn_mode(sfn_mode), .auto_eoi(auto_eoi),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_level(cmd_level), .ack(ack),
    .int_req(int_req), .int_level(int_level), .ack_done(ack_done), .ack_level(ack_level),
    .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = m; cyc(1); irq_in = '0;
  endtask

  task automatic cmd(input int op, input int lvl);
    cmd_wr = 1'b1; cmd_op = 3'(op); cmd_level = 3'(lvl);
    cyc(1); cmd_wr = 1'b0;
  endtask

  task automatic do_ack(input int exp);
    exp_q.push_back(exp);
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] m);
    mask_wr = 1'b1; mask_data = m; cyc(1); mask_wr = 1'b0;
  endtask

  task automatic wr_trig(input logic [7:0] m);
    trig_wr = 1'b1; trig_data = m; cyc(1); trig_wr = 1'b0;
  endtask

  // Scoreboard monitor: one expected line per acknowledge
  always @(negedge clk) begin
    if (!rst && ack_done) begin
      if (exp_q.size() == 0) check("R5 unexpected ack_done", 1, 0);
      else check("R5 ack_level", int'(ack_level), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    // R1
    check("R1 int_req", int'(int_req), 0);
    check("R1 irr", int'(irr_out), 0);
    check("R1 isr", int'(isr_out), 0);
    check("R1 ack_level", int'(ack_level), 0);

    // R13 / R4 / R2: edge on line 4
    irq_in = 8'h10; cyc(1); irq_in = '0;
    check("R4 edge capture", int'(irr_out), 8'h10);
    check("R13 int_req lags", int'(int_req), 0);
    cyc(1);
    check("R13 int_req", int'(int_req), 1);
    check("R2 int_level", int'(int_level), 4);
    do_ack(4);
    check("R5 isr", int'(isr_out), 8'h10);
    check("R5 edge irr cleared", int'(irr_out), 0);

    // R3: lower priority blocked, higher nests
    pulse(8'h20); cyc(2);
    check("R3 blocked irr", int'(irr_out), 8'h20);
    check("R3 blocked", int'(int_req), 0);
    pulse(8'h02); cyc(2);
    check("R3 nest req", int'(int_req), 1);
    check("R3 nest level", int'(int_level), 1);
    do_ack(1);
    check("R5 isr nested", int'(isr_out), 8'h12);

    // R7: general and line-specific end-of-interrupt
    cmd(1, 0); cyc(1);
    check("R7 eoi top", int'(isr_out), 8'h10);
    check("R7 still blocked", int'(int_req), 0);
    cmd(1, 0); cyc(1);
    check("R7 eoi top 2", int'(isr_out), 0);
    check("R7 level 5", int'(int_level), 5);
    do_ack(5);
    cmd(2, 5); cyc(1);
    check("R7 eoi line", int'(isr_out), 0);

    // R11 / R8
    wr_mask(8'h08);
    pulse(8'h08); cyc(2);
    check("R11 masked irr", int'(irr_out), 8'h08);
    check("R11 masked", int'(int_req), 0);
    cmd(2, 3);
    check("R8 eoi drops pending", int'(irr_out), 0);
    pulse(8'h08); cyc(2);
    wr_mask(8'h00); cyc(1);
    check("R11 unmasked", int'(int_req), 1);
    check("R11 level", int'(int_level), 3);
    do_ack(3); cmd(2, 3);

    // R4 / R5 level mode
    wr_trig(8'h40);
    irq_in = 8'h40; cyc(2);
    check("R4 level irr", int'(irr_out), 8'h40);
    do_ack(6);
    check("R5 level irr kept", int'(irr_out), 8'h40);
    irq_in = '0; cyc(2);
    check("R4 level follows", int'(irr_out), 0);
    cmd(2, 6); wr_trig(8'h00);

    // R2 / R7 rotation
    cmd(5, 4);
    pulse(8'h41); cyc(2);
    check("R2 rotated winner", int'(int_level), 6);
    do_ack(6); cyc(1);
    check("R2 line0 ranks low", int'(int_req), 0);
    cmd(3, 0); cyc(1);
    check("R7 rotate eoi req", int'(int_req), 1);
    check("R7 rotate eoi level", int'(int_level), 0);
    do_ack(0); cmd(1, 0); cmd(5, 7); cyc(1);
    check("R7 isr clear", int'(isr_out), 0);

    // R6 auto end-of-interrupt with rotation
    auto_eoi = 1'b1; cmd(6, 0);
    pulse(8'h08); cyc(2);
    do_ack(3);
    check("R6 isr untouched", int'(isr_out), 0);
    pulse(8'h24); cyc(2);
    check("R6 rotated base", int'(int_level), 5);
    do_ack(5);
    do_ack(2);
    cmd(7, 0); auto_eoi = 1'b0; cmd(5, 7); cyc(1);

    // R12 acknowledge with nothing valid
    pulse(8'h10); cyc(2); do_ack(4);
    pulse(8'h20); cyc(2);
    check("R12 not valid", int'(int_req), 0);
    do_ack(7); cyc(1);
    check("R12 isr unchanged", int'(isr_out), 8'h10);
    check("R12 irr unchanged", int'(irr_out), 8'h20);
    cmd(1, 0); cyc(1); do_ack(5); cmd(1, 0);

    // R9 forced edge lines
    wr_trig(8'hFF);
    irq_in = 8'h82; cyc(2);
    check("R9 winner", int'(int_level), 1);
    do_ack(1); cyc(1);
    check("R9 line1 stays edge", int'(irr_out), 8'h80);
    irq_in = '0; cmd(2, 1); cyc(2);
    check("R9 cleanup irr", int'(irr_out), 0);
    wr_trig(8'h00);

    // R10 special nested mode on the cascade line
    sfn_mode = 1'b1;
    pulse(8'h04); cyc(2); do_ack(2);
    check("R10 isr cascade", int'(isr_out), 8'h04);
    pulse(8'h04); cyc(2);
    check("R10 cascade re-requests", int'(int_req), 1);
    check("R10 level", int'(int_level), 2);
    sfn_mode = 1'b0; cyc(2);
    check("R10 blocked without mode", int'(int_req), 0);
    cmd(2, 2); cyc(2);
    check("R8 cascade dropped", int'(irr_out), 0);

    cyc(3);
    check("R5 all acks seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule